// File: doc/BRIEF.md
# Row-Balanced Sparse Matrix-Vector Engine

This block computes `y = W·v` for a pruned weight matrix in which every row keeps the same number of nonzero entries. Each row is held as a fixed-length list of entries. An entry pairs a signed 8-bit fixed-point weight with the column index of the input-vector element it multiplies. The rows are spread over a parameterised array of processing elements (PEs). Row `g*PES + p` goes to PE `p` in row group `g`. All PEs take one entry per cycle, so every PE finishes a row in exactly `NNZ` cycles. The array then moves straight to the next row group, with no stall or balancing logic.

The input vector is written through a simple write port into a register file inside the block. A start pulse then launches the whole product. The engine puts out the address of the entry it is consuming: a row group and a slot within the row. The surrounding storage answers in the same cycle with one entry per PE. Each row group yields one result word per PE, saturated from a 24-bit accumulator to 16 bits and marked by a one-cycle valid. A done flag follows the last group.

With balanced rows, the total time is `NNZ` cycles per row group, whatever the data. For example, three entries per row finish in 3 cycles. An unbalanced layout would instead be paced by its longest row.

Top module: `rowbal_spmv`

## Requirements
- R1: After reset, `resValid` and `done` are 0 and every lane of `resData` is 0.
- R2: When `vecWrEn` is 1 at a clock edge, vector element `vecWrAddr` takes the value of `vecWrData` (signed 8-bit). A later write to the same address replaces it.
- R3: Entry lane `p` is read from `entWeight[p*8 +: 8]` (signed weight) and `entCol[p*IDXW +: IDXW]` (column index, IDXW = ceil(log2(VEC_LEN))). Lane `p` in row group `g` belongs to matrix row `g*PES + p`, and its result appears in `resData[p*16 +: 16]`.
- R4: Each result equals the signed sum over the row's entries of weight × vector[column], accumulated in 24 bits. Repeated column indices add up.
- R5: A row sum above 32767 comes out as 32767, and one below -32768 comes out as -32768.
- R6: A start pulse seen while idle begins a run. In the cycle that is `c` cycles after the start edge (c = 0 … NNZ·GROUPS−1), `fetchGroup` = c / NNZ and `fetchSlot` = c mod NNZ. One entry per lane is consumed per cycle, with no gaps.
- R7: The results of row group `g` are presented with `resValid` = 1 and `resGroup` = g for exactly one cycle, NNZ·(g+1) cycles after the start edge. `resData` holds its value until the next result.
- R8: `done` rises one cycle after the last row group's results are valid. It stays 1 until a new run is accepted.
- R9: A start pulse during a run is ignored: the fetch sequence and result timing continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run when idle |
| vecWrEn | input | 1 | Input-vector write enable |
| vecWrAddr | input | IDXW | Input-vector element address |
| vecWrData | input | 8 | Signed input-vector element |
| fetchGroup | output | GRPW | Row group of the entry being consumed |
| fetchSlot | output | SLOTW | Slot within the row of the entry being consumed |
| entWeight | input | PES·8 | One signed weight per lane |
| entCol | input | PES·IDXW | One column index per lane |
| resValid | output | 1 | Result words valid this cycle |
| resGroup | output | GRPW | Row group the results belong to |
| resData | output | PES·16 | Saturated result per lane |
| done | output | 1 | Run finished |

## Verification
Counting from the edge that samples start, the entry address for cycle c is due at once, and group g's results are due NNZ·(g+1) edges later. Done is due one edge after the last group. The bench counts edges from the start edge and samples each output on the falling edge after the edge where it is due. It also checks that valid is absent on the other cycles and that data still holds one cycle after each result. Expected sums come from a dense copy of the matrix with zeros in place, multiplied by the bench's own vector model and clamped to 16 bits.

// File: rtl/spmv_pkg.sv
package spmv_pkg;

  // Strobes sent from the sequencer to the PE datapath each cycle.
  typedef struct packed {
    logic macEn;      // consume one entry this cycle
    logic firstSlot;  // entry starts a new row: restart accumulation
    logic lastSlot;   // entry ends the row: capture the result
  } macStrobes_t;

endpackage

// File: rtl/rowbal_spmv_ctl.sv
module rowbal_spmv_ctl
  import spmv_pkg::*;
#(
  parameter int NNZ    = 3,
  parameter int GROUPS = 3,
  localparam int SLOTW = (NNZ > 1) ? $clog2(NNZ) : 1,
  localparam int GRPW  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output macStrobes_t      strb,
  output logic [SLOTW-1:0] fetchSlot,
  output logic [GRPW-1:0]  fetchGroup,
  output logic             busy,
  output logic             resValid,
  output logic [GRPW-1:0]  resGroup,
  output logic             done
);

  localparam logic [SLOTW-1:0] LAST_SLOT  = SLOTW'(NNZ - 1);
  localparam logic [GRPW-1:0]  LAST_GROUP = GRPW'(GROUPS - 1);

  logic [SLOTW-1:0] slotQ;
  logic [GRPW-1:0]  groupQ;
  logic             slotEnd;
  logic             groupEnd;

  assign slotEnd  = (slotQ == LAST_SLOT);
  assign groupEnd = (groupQ == LAST_GROUP);

  always_comb begin
    strb.macEn     = busy;
    strb.firstSlot = (slotQ == '0);
    strb.lastSlot  = slotEnd;
  end

  assign fetchSlot  = slotQ;
  assign fetchGroup = groupQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      slotQ    <= '0;
      groupQ   <= '0;
      resValid <= 1'b0;
      resGroup <= '0;
    end else begin
      resValid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          slotQ  <= '0;
          groupQ <= '0;
        end
      end else if (slotEnd) begin
        slotQ    <= '0;
        resValid <= 1'b1;
        resGroup <= groupQ;
        if (groupEnd) begin
          busy   <= 1'b0;
          groupQ <= '0;
        end else begin
          groupQ <= groupQ + 1'b1;
        end
      end else begin
        slotQ <= slotQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else if (!busy && start) begin
      done <= 1'b0;
    end else if (resValid && resGroup == LAST_GROUP) begin
      done <= 1'b1;
    end
  end

endmodule

// File: rtl/rowbal_spmv_pe.sv
module rowbal_spmv_pe
  import spmv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  macStrobes_t              strb,
  input  logic signed [DATA_W-1:0] weight,
  input  logic signed [DATA_W-1:0] operand,
  output logic signed [OUT_W-1:0]  result
);

  localparam int HEAD_W = ACC_W - OUT_W + 1;

  logic signed [ACC_W-1:0]    accQ;
  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    prodExt;
  logic signed [ACC_W-1:0]    sum;
  logic signed [OUT_W-1:0]    clamped;
  logic [HEAD_W-1:0]          head;

  assign prod    = weight * operand;
  assign prodExt = ACC_W'(prod);
  assign sum     = (strb.firstSlot ? '0 : accQ) + prodExt;
  assign head    = sum[ACC_W-1:OUT_W-1];

  always_comb begin
    if (head == '0 || head == '1) begin
      clamped = sum[OUT_W-1:0];
    end else if (sum[ACC_W-1]) begin
      clamped = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      clamped = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ   <= '0;
      result <= '0;
    end else if (strb.macEn) begin
      accQ <= sum;
      if (strb.lastSlot) begin
        result <= clamped;
      end
    end
  end

endmodule

// File: rtl/rowbal_spmv_dp.sv
module rowbal_spmv_dp
  import spmv_pkg::*;
#(
  parameter int PES     = 4,
  parameter int VEC_LEN = 16,
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 16,
  localparam int IDXW   = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  macStrobes_t             strb,
  input  logic                    vecWrEn,
  input  logic [IDXW-1:0]         vecWrAddr,
  input  logic [DATA_W-1:0]       vecWrData,
  input  logic [PES*DATA_W-1:0]   entWeight,
  input  logic [PES*IDXW-1:0]     entCol,
  output logic [PES*OUT_W-1:0]    resData
);

  logic [DATA_W-1:0] vecRegs [VEC_LEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < VEC_LEN; i++) vecRegs[i] <= '0;
    end else if (vecWrEn) begin
      vecRegs[vecWrAddr] <= vecWrData;
    end
  end

  for (genvar p = 0; p < PES; p++) begin : g_lane
    logic [IDXW-1:0]          colSel;
    logic signed [DATA_W-1:0] laneOperand;
    logic signed [DATA_W-1:0] laneWeight;
    logic signed [OUT_W-1:0]  laneResult;

    assign colSel      = entCol[p*IDXW +: IDXW];
    assign laneOperand = vecRegs[colSel];
    assign laneWeight  = entWeight[p*DATA_W +: DATA_W];

    rowbal_spmv_pe #(
      .DATA_W(DATA_W),
      .ACC_W (ACC_W),
      .OUT_W (OUT_W)
    ) u_pe (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb   (strb),
      .weight (laneWeight),
      .operand(laneOperand),
      .result (laneResult)
    );

    assign resData[p*OUT_W +: OUT_W] = laneResult;
  end

endmodule

// File: rtl/rowbal_spmv.sv
module rowbal_spmv
  import spmv_pkg::*;
#(
  parameter int PES      = 4,
  parameter int NNZ      = 3,
  parameter int VEC_LEN  = 16,
  parameter int NUM_ROWS = 12,
  parameter int DATA_W   = 8,
  parameter int ACC_W    = 24,
  parameter int OUT_W    = 16,
  localparam int GROUPS  = NUM_ROWS / PES,
  localparam int IDXW    = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1,
  localparam int SLOTW   = (NNZ > 1) ? $clog2(NNZ) : 1,
  localparam int GRPW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  vecWrEn,
  input  logic [IDXW-1:0]       vecWrAddr,
  input  logic [DATA_W-1:0]     vecWrData,
  output logic [GRPW-1:0]       fetchGroup,
  output logic [SLOTW-1:0]      fetchSlot,
  input  logic [PES*DATA_W-1:0] entWeight,
  input  logic [PES*IDXW-1:0]   entCol,
  output logic                  resValid,
  output logic [GRPW-1:0]       resGroup,
  output logic [PES*OUT_W-1:0]  resData,
  output logic                  done
);

  macStrobes_t strb;
  logic        busy;

  rowbal_spmv_ctl #(
    .NNZ   (NNZ),
    .GROUPS(GROUPS)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .strb      (strb),
    .fetchSlot (fetchSlot),
    .fetchGroup(fetchGroup),
    .busy      (busy),
    .resValid  (resValid),
    .resGroup  (resGroup),
    .done      (done)
  );

  rowbal_spmv_dp #(
    .PES    (PES),
    .VEC_LEN(VEC_LEN),
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W),
    .OUT_W  (OUT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .vecWrEn  (vecWrEn),
    .vecWrAddr(vecWrAddr),
    .vecWrData(vecWrData),
    .entWeight(entWeight),
    .entCol   (entCol),
    .resData  (resData)
  );

endmodule

// File: rtl/rowbal_spmv_chk.sv
module rowbal_spmv_chk #(
  parameter int NNZ    = 3,
  parameter int GROUPS = 3,
  parameter int SLOTW  = 2,
  parameter int GRPW   = 2,
  parameter int RES_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [SLOTW-1:0] fetchSlot,
  input logic [GRPW-1:0]  fetchGroup,
  input logic             resValid,
  input logic [GRPW-1:0]  resGroup,
  input logic [RES_W-1:0] resData,
  input logic             done
);

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fetchSlot) <= NNZ - 1) && (int'(fetchGroup) <= GROUPS - 1)); // R6

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (int'($past(fetchSlot)) != NNZ - 1)
      |-> int'(fetchSlot) == int'($past(fetchSlot)) + 1); // R6

  AST_VALID_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> $past(busy) && (int'($past(fetchSlot)) == NNZ - 1)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> $stable(resData)); // R7

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(resValid) && (int'($past(resGroup)) == GROUPS - 1)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (int'(fetchSlot) != NNZ - 1)
      |=> busy && (fetchGroup == $past(fetchGroup))); // R9

endmodule

bind rowbal_spmv rowbal_spmv_chk #(
  .NNZ   (NNZ),
  .GROUPS(GROUPS),
  .SLOTW (SLOTW),
  .GRPW  (GRPW),
  .RES_W (PES*OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .fetchSlot (fetchSlot),
  .fetchGroup(fetchGroup),
  .resValid  (resValid),
  .resGroup  (resGroup),
  .resData   (resData),
  .done      (done)
);

// File: tb/sim_rowbal_spmv.sv
module sim_rowbal_spmv;

  localparam int PES = 4;
  localparam int NNZ = 3;
  localparam int VL  = 16;
  localparam int NR  = 12;
  localparam int GR  = NR / PES;
  localparam int IW  = $clog2(VL);
  localparam int SW  = $clog2(NNZ);
  localparam int GW  = $clog2(GR);
  localparam int TOTAL = NNZ * GR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vecWrEn = 1'b0;
  logic [IW-1:0] vecWrAddr = '0;
  logic [7:0] vecWrData = '0;
  logic [GW-1:0] fetchGroup;
  logic [SW-1:0] fetchSlot;
  logic [PES*8-1:0] entWeight;
  logic [PES*IW-1:0] entCol;
  logic resValid;
  logic [GW-1:0] resGroup;
  logic [PES*16-1:0] resData;
  logic done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  int romW [NR][NNZ];
  int romC [NR][NNZ];
  int vecModel [VL];
  int expRes [NR];

  always #10 clk = ~clk;

  rowbal_spmv u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr), .vecWrData(vecWrData),
    .fetchGroup(fetchGroup), .fetchSlot(fetchSlot),
    .entWeight(entWeight), .entCol(entCol),
    .resValid(resValid), .resGroup(resGroup), .resData(resData), .done(done)
  );

  // Entry storage answering the fetch address in the same cycle (R3 lane layout).
  always_comb begin
    for (int p = 0; p < PES; p++) begin
      int row;
      int sl;
      row = int'(fetchGroup) * PES + p;
      sl  = int'(fetchSlot);
      if (row < NR && sl < NNZ) begin
        entWeight[p*8 +: 8] = 8'(romW[row][sl]);
        entCol[p*IW +: IW]  = IW'(romC[row][sl]);
      end else begin
        entWeight[p*8 +: 8] = '0;
        entCol[p*IW +: IW]  = '0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // Dense reference: expand each row with zeros, then multiply in full (R4, R5).
  task automatic computeExpected();
    for (int r = 0; r < NR; r++) begin
      int dense [VL];
      int acc;
      for (int c = 0; c < VL; c++) dense[c] = 0;
      for (int k = 0; k < NNZ; k++) dense[romC[r][k]] += romW[r][k];
      acc = 0;
      for (int c = 0; c < VL; c++) acc += dense[c] * vecModel[c];
      expRes[r] = sat16(acc);
    end
  endtask

  task automatic writeVec(input int addr, input int val);
    @(negedge clk);
    vecWrEn = 1'b1;
    vecWrAddr = IW'(addr);
    vecWrData = 8'(val);
    vecModel[addr] = val;
    @(negedge clk);
    vecWrEn = 1'b0;
  endtask

  function automatic int srand8();
    return int'($urandom_range(255)) - 128;
  endfunction

  task automatic randomMatrix();
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NNZ; k++) begin
        romW[r][k] = srand8();
        romC[r][k] = int'($urandom_range(VL - 1));
      end
  endtask

  task automatic randomVector();
    for (int c = 0; c < VL; c++) writeVec(c, srand8());
  endtask

  task automatic laneCheck(input int g, input string req);
    for (int p = 0; p < PES; p++) begin
      int act;
      act = int'($signed(resData[p*16 +: 16]));
      chk(act == expRes[g*PES + p], req, act, expRes[g*PES + p]);
    end
  endtask

  task automatic runJob(input bit busyStart);
    computeExpected();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);           // start edge has passed: c = 0
    start = 1'b0;
    for (int c = 0; c <= TOTAL + 1; c++) begin
      if (c > 0) @(negedge clk);
      if (busyStart && c == 2) start = 1'b1;
      if (busyStart && c == 3) start = 1'b0;
      if (c < TOTAL) begin
        chk(int'(fetchGroup) == c / NNZ, "R6 group", int'(fetchGroup), c / NNZ);
        chk(int'(fetchSlot) == c % NNZ, "R6 slot", int'(fetchSlot), c % NNZ);
      end
      if (c > 0 && c <= TOTAL && c % NNZ == 0) begin
        chk(resValid == 1'b1, "R7 valid", int'(resValid), 1);
        chk(int'(resGroup) == c / NNZ - 1, "R7 group", int'(resGroup), c / NNZ - 1);
        laneCheck(c / NNZ - 1, "R4 result");
      end else begin
        chk(resValid == 1'b0, "R7 no valid", int'(resValid), 0);
        if (c > NNZ && (c - 1) % NNZ == 0) laneCheck((c - 1) / NNZ - 1, "R7 hold");
      end
      if (c >= TOTAL)
        chk(done == (c == TOTAL + 1), "R8 done", int'(done), int'(c == TOTAL + 1));
      else if (busyStart)
        chk(done == 1'b0, "R9 done low", int'(done), 0);
    end
    repeat (2) @(negedge clk);
    chk(done == 1'b1, "R8 done held", int'(done), 1);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int c = 0; c < VL; c++) vecModel[c] = 0;
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NNZ; k++) begin
        romW[r][k] = 0;
        romC[r][k] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(resValid == 1'b0, "R1 valid", int'(resValid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(resData == '0, "R1 data", int'(resData[15:0]), 0);

    // Random matrix and vector (R2, R3, R4, R6, R7, R8)
    randomVector();
    randomMatrix();
    runJob(1'b0);

    // Saturation corners (R5): positive overflow on group 0, negative on group 1
    for (int c = 0; c < VL; c++) writeVec(c, -128);
    randomMatrix();
    for (int r = 0; r < PES; r++)
      for (int k = 0; k < NNZ; k++) romW[r][k] = -128;
    for (int r = PES; r < 2 * PES; r++)
      for (int k = 0; k < NNZ; k++) romW[r][k] = 127;
    runJob(1'b0);
    chk(expRes[0] == 32767, "R5 model high", expRes[0], 32767);
    chk(expRes[PES] == -32768, "R5 model low", expRes[PES], -32768);

    // Overwrite one element, repeated columns, start pulse mid-run (R2, R4, R9)
    randomVector();
    writeVec(5, 77);
    randomMatrix();
    for (int k = 0; k < NNZ; k++) romC[0][k] = 5;
    runJob(1'b1);

    // More random runs
    for (int j = 0; j < 4; j++) begin
      randomVector();
      randomMatrix();
      runJob(j[0]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule